// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-level, synthesizable model of a single-ported synchronous static RAM. It has a 36-bit word made of four 9-bit byte lanes, a burst address generator, and a registered read path. All of its control, address and write-data inputs take effect only at the rising clock edge. A cycle can be opened by two address strobes: one driven by a processor and one driven by a memory controller. Three chip enables gate each new cycle. Once a burst is open, it runs on from the loaded address. An advance input either steps the burst to the next address or holds it where it is.

Writes can cover the whole word through a global write input or only chosen lanes through a byte-write qualifier and per-lane selects. A cycle opened by the processor strobe is always a read, and any data it brings is ignored. Read data passes through an address register and then an output register. The bidirectional data bus is modelled as a data-out vector plus a drive flag. The output enable and the sleep input gate that flag without waiting for a clock edge. The burst order is selected by a static strap input: either linear or interleaved. The array depth is the parameter `ADDR_W`. A full-size part uses 16, and the default of 10 keeps elaboration small.

Top module: `sram_pipe_burst`

## Requirements
- R1: The array holds 2^ADDR_W words of 36 bits. Lane n occupies bits 9n+8 down to 9n, and each lane is written independently of the others.
- R2: A read registered at clock edge k puts the addressed word on `dout` after edge k+1. If `oe_n` is low, `dout_oe` is high from then on. Nothing new appears after edge k itself.
- R3: A new burst base is loaded from `addr` when a strobe is low and the enables are active (`en1_n`=0, `en2`=1, `en3_n`=0).
- R4: `ctrl_strb_n` low with `en1_n` high is a deselect: the burst ends and `dout_oe` goes low. When `en1_n` is high, `proc_strb_n` is ignored and the cycle behaves as if it were high.
- R5: Either strobe with `en2` low or `en3_n` high is a deselect. The burst ends, the output goes undriven, and later continuation cycles neither read nor write.
- R6: A cycle opened by `proc_strb_n` is a read whatever the write inputs are. Write data for that burst is taken on the following continuation cycles.
- R7: `gwr_n` low writes all four lanes. Otherwise, `bwr_en_n` low writes each lane whose `lane_sel_n` bit is low. With `bwr_en_n` high, or all selects high, the cycle is a read.
- R8: With neither strobe in effect and a burst open, `adv_n` low moves to the next burst address and `adv_n` high keeps the current one. This applies to reads and to writes.
- R9: The upper address bits stay fixed through a burst, and the two low bits wrap after four addresses. With `lin_order`=1 they run base+n mod 4; with `lin_order`=0 they run base XOR n.
- R10: `sleep` high drops `dout_oe` at once, performs no access and ends the burst. After `sleep` falls, `dout_oe` stays low until a new read returns.
- R11: `oe_n` high forces `dout_oe` low without waiting for a clock edge. After a write cycle, `dout_oe` stays low until a read returns.
- R12: Synchronous active-high `rst` clears `dout`, the drive flag and the burst state, and leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, loaded when a cycle opens |
| proc_strb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| en1_n | input | 1 | Chip enable 1, active low |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwr_en_n | input | 1 | Byte-write qualifier, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low, bit n is lane n |
| oe_n | input | 1 | Output enable, active low, applied without a clock edge |
| sleep | input | 1 | Sleep, active high |
| lin_order | input | 1 | Static burst-order strap, 1 linear, 0 interleaved |
| din | input | 36 | Write data |
| dout | output | 36 | Output register contents |
| dout_oe | output | 1 | High when the data bus would be driven |

## Verification
A vector table first fills one four-word block through a controller-opened write burst. It then drives processor-opened reads, byte-lane writes, held and stepped continuation cycles, and every deselect path. Each of these patterns separates two outcomes that would otherwise look the same. A held read separates hold from step. Reading back a lane-merged word separates selected lanes from unselected ones. Reading back a location after an ignored write burst shows whether a deselect really closed the burst. A processor strobe with enable 1 high shows whether it is ignored (the burst steps on) or taken (a new base is loaded). Directed sequences then run an interleaved burst whose order differs from the linear one, toggle the output enable between edges, enter and leave sleep in the middle of a burst, and reset between accesses to show that the memory contents survive.

// File: rtl/sram_pkg.sv
package sram_pkg;

  localparam int NLANES    = 4;
  localparam int LANE_BITS = 9;
  localparam int WORD_BITS = NLANES * LANE_BITS;

  typedef enum logic [1:0] {
    CK_IDLE  = 2'd0,
    CK_DESEL = 2'd1,
    CK_LOAD  = 2'd2,
    CK_CONT  = 2'd3
  } cyc_kind_e;

  // Lanes to write: global write wins, else qualified per-lane selects.
  function automatic logic [NLANES-1:0] lane_mask(input logic gw_n,
                                                  input logic bwe_n,
                                                  input logic [NLANES-1:0] sel_n);
    if (!gw_n)       return '1;
    else if (!bwe_n) return ~sel_n;
    else             return '0;
  endfunction

  // Low two address bits of burst beat cnt starting at base.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic linear);
    return linear ? (base + cnt) : (base ^ cnt);
  endfunction

endpackage

// File: rtl/sram_burst_gen.sv
module sram_burst_gen #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-1:0] base_in,
  output logic [AW-1:0] addr_eff
);
  import sram_pkg::*;

  logic [AW-1:0] base_q, base_n;
  logic [1:0]    cnt_q, cnt_n;

  always_comb begin
    base_n = load ? base_in : base_q;
    if (load)      cnt_n = 2'd0;
    else if (step) cnt_n = cnt_q + 2'd1;
    else           cnt_n = cnt_q;
  end

  assign addr_eff = {base_n[AW-1:2], burst_low(base_n[1:0], cnt_n, linear)};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

  // R3: a load sets the base and restarts the beat count
  a_r3_load_base: assert property (@(posedge clk) disable iff (rst)
    load |=> (base_q == $past(base_in)) && (cnt_q == 2'd0));
  // R8: a step moves exactly one beat, wrapping after four
  a_r8_step_one: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> cnt_q == $past(cnt_q) + 2'd1);
  // R8: a hold keeps base and beat
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(base_q) && $stable(cnt_q));

endmodule

// File: rtl/sram_cycle_dec.sv
module sram_cycle_dec
  import sram_pkg::*;
(
  input  logic              proc_n,
  input  logic              ctrl_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NLANES-1:0] sel_n,
  input  logic              sleep,
  input  logic              burst_act,
  output cyc_kind_e         kind,
  output logic              proc_go,
  output logic              step,
  output logic [NLANES-1:0] wr_mask,
  output logic              rd_go
);

  logic start, chip_ok, access;
  logic [NLANES-1:0] req_mask;

  assign proc_go  = !proc_n && !en1_n;
  assign start    = proc_go || !ctrl_n;
  assign chip_ok  = !en1_n && en2 && !en3_n;
  assign req_mask = lane_mask(gw_n, bwe_n, sel_n);

  always_comb begin
    kind    = CK_IDLE;
    step    = 1'b0;
    wr_mask = '0;
    access  = 1'b0;
    if (sleep) begin
      kind = CK_DESEL;
    end else if (start) begin
      if (!chip_ok) begin
        kind = CK_DESEL;
      end else begin
        kind    = CK_LOAD;
        access  = 1'b1;
        wr_mask = proc_go ? '0 : req_mask;
      end
    end else if (burst_act) begin
      kind    = CK_CONT;
      access  = 1'b1;
      step    = !adv_n;
      wr_mask = req_mask;
    end
  end

  assign rd_go = access && (wr_mask == '0);

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 10
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            sleep,
  input  logic [AW-1:0]                   addr,
  input  logic [sram_pkg::NLANES-1:0]     wr_mask,
  input  logic [sram_pkg::WORD_BITS-1:0]  wr_data,
  input  logic                            rd_go,
  output logic [sram_pkg::WORD_BITS-1:0]  dout,
  output logic                            dout_vld
);
  import sram_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [WORD_BITS-1:0] mem [DEPTH];
  logic                 rd_q;
  logic [AW-1:0]        rd_addr_q;

  always_ff @(posedge clk) begin
    for (int l = 0; l < NLANES; l++) begin
      if (wr_mask[l])
        mem[addr][l*LANE_BITS +: LANE_BITS] <= wr_data[l*LANE_BITS +: LANE_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
      dout      <= '0;
      dout_vld  <= 1'b0;
    end else begin
      rd_q      <= rd_go;
      rd_addr_q <= addr;
      if (rd_q && !sleep) dout <= mem[rd_addr_q];
      dout_vld  <= rd_q && !sleep;
    end
  end

  // R2: a registered read reaches the output one edge later
  a_r2_read_return: assert property (@(posedge clk) disable iff (rst)
    (rd_q && !sleep) |=> dout_vld);
  // R11: without a pending read the output is not valid
  a_r11_no_read_no_drive: assert property (@(posedge clk) disable iff (rst)
    !rd_q |=> !dout_vld);
  // R10: sleep blocks the return
  a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !dout_vld);
  // R7: read and write never share a cycle
  a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> (wr_mask == '0));

endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst #(
  parameter int ADDR_W = 10
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic                                proc_strb_n,
  input  logic                                ctrl_strb_n,
  input  logic                                en1_n,
  input  logic                                en2,
  input  logic                                en3_n,
  input  logic                                adv_n,
  input  logic                                gwr_n,
  input  logic                                bwr_en_n,
  input  logic [sram_pkg::NLANES-1:0]         lane_sel_n,
  input  logic                                oe_n,
  input  logic                                sleep,
  input  logic                                lin_order,
  input  logic [sram_pkg::WORD_BITS-1:0]      din,
  output logic [sram_pkg::WORD_BITS-1:0]      dout,
  output logic                                dout_oe
);
  import sram_pkg::*;

  // named internal events
  cyc_kind_e          cyc_kind;
  logic               cyc_load, cyc_desel, cyc_step, proc_go;
  logic [NLANES-1:0]  wr_mask;
  logic               rd_go;
  logic               burst_act_q;
  logic [ADDR_W-1:0]  addr_eff;
  logic               dout_vld;

  sram_cycle_dec u_dec (
    .proc_n    (proc_strb_n),
    .ctrl_n    (ctrl_strb_n),
    .en1_n     (en1_n),
    .en2       (en2),
    .en3_n     (en3_n),
    .adv_n     (adv_n),
    .gw_n      (gwr_n),
    .bwe_n     (bwr_en_n),
    .sel_n     (lane_sel_n),
    .sleep     (sleep),
    .burst_act (burst_act_q),
    .kind      (cyc_kind),
    .proc_go   (proc_go),
    .step      (cyc_step),
    .wr_mask   (wr_mask),
    .rd_go     (rd_go)
  );

  assign cyc_load  = (cyc_kind == CK_LOAD);
  assign cyc_desel = (cyc_kind == CK_DESEL);

  always_ff @(posedge clk) begin
    if (rst)            burst_act_q <= 1'b0;
    else if (cyc_desel) burst_act_q <= 1'b0;
    else if (cyc_load)  burst_act_q <= 1'b1;
  end

  sram_burst_gen #(.AW(ADDR_W)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .load     (cyc_load),
    .step     (cyc_step),
    .linear   (lin_order),
    .base_in  (addr),
    .addr_eff (addr_eff)
  );

  sram_array #(.AW(ADDR_W)) u_arr (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .addr     (addr_eff),
    .wr_mask  (wr_mask),
    .wr_data  (din),
    .rd_go    (rd_go),
    .dout     (dout),
    .dout_vld (dout_vld)
  );

  assign dout_oe = dout_vld && !oe_n && !sleep;

  // R5: any deselect closes the burst
  a_r5_desel_closes: assert property (@(posedge clk) disable iff (rst)
    cyc_desel |=> !burst_act_q);
  // R4: a deselect leaves nothing to drive two edges later
  a_r4_desel_quiet: assert property (@(posedge clk) disable iff (rst)
    cyc_desel |=> ##1 !dout_vld);
  // R6: a processor-opened cycle writes nothing even with write inputs low
  a_r6_proc_reads: assert property (@(posedge clk) disable iff (rst)
    (cyc_load && proc_go) |-> rd_go);
  // R8: continuation needs an open burst
  a_r8_cont_needs_burst: assert property (@(posedge clk) disable iff (rst)
    (cyc_kind == CK_CONT) |-> burst_act_q);

endmodule

// File: tb/tb_sram_pipe_burst.sv
module tb_sram_pipe_burst;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          ps_n, cs_n, e1n, e2, e3n, adv_n, gw_n, bwe_n, oe_n, sleep, lin;
  logic [3:0]    bw_n;
  logic [35:0]   din, dout;
  logic          dout_oe;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sram_pipe_burst #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .proc_strb_n(ps_n), .ctrl_strb_n(cs_n),
    .en1_n(e1n), .en2(e2), .en3_n(e3n), .adv_n(adv_n), .gwr_n(gw_n),
    .bwr_en_n(bwe_n), .lane_sel_n(bw_n), .oe_n(oe_n), .sleep(sleep),
    .lin_order(lin), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic ps_n, cs_n, e1n, e2, e3n, adv_n, gw_n, bwe_n;
    logic [3:0]  bw_n;
    logic [9:0]  a;
    logic [35:0] d;
    logic chk, oe;
    logic [35:0] q;
  } vec_t;

  function automatic vec_t v(input logic [23:0] tag,
                             input logic p, c, e1, en2v, e3, adv, gw, bwe,
                             input logic [3:0] bw, input logic [9:0] a,
                             input logic [35:0] d, input logic oe,
                             input logic [35:0] q);
    return '{tag, p, c, e1, en2v, e3, adv, gw, bwe, bw, a, d, 1'b1, oe, q};
  endfunction

  // bench view of a lane write: lane n is bits 9n+8..9n
  function automatic logic [35:0] merge(input logic [35:0] old_w,
                                        input logic [35:0] new_w,
                                        input logic [3:0] lanes);
    logic [35:0] r = old_w;
    for (int l = 0; l < 4; l++)
      if (lanes[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
    return r;
  endfunction

  localparam logic [35:0] D0 = 36'h123456789, D1 = 36'h2468ACE13;
  localparam logic [35:0] D2 = 36'h30F0F0F0F, D3 = 36'h45A5AA5A5;
  localparam logic [35:0] D4 = 36'h511112222, W  = 36'hEDCBA9876;
  localparam logic [35:0] D5 = 36'h077665544, JK = 36'hBBBBBBBBB;
  localparam logic [35:0] MRG = merge(D1, W, 4'b0101);

  localparam int NV = 25;
  //                   tag    ps cs e1 e2 e3 adv gw bwe bw  addr    data  oe  q
  localparam vec_t TBL [NV] = '{
    v("R7 ", 1,0,0,1,0,1,0,1,4'hF,10'h010,D0, 0,0),   // controller global write
    v("R11", 1,1,0,1,0,0,0,1,4'hF,10'h000,D1, 0,0),   // R8 step write 011
    v("R8 ", 1,1,0,1,0,0,0,1,4'hF,10'h000,D2, 0,0),   // 012
    v("R8 ", 1,1,0,1,0,0,0,1,4'hF,10'h000,D3, 0,0),   // 013
    v("R9 ", 1,1,0,1,0,0,0,1,4'hF,10'h000,D4, 0,0),   // wraps to 010
    v("R2 ", 0,1,0,1,0,1,0,1,4'hF,10'h012,JK, 0,0),   // R6 proc read, write ignored
    v("R6 ", 1,1,0,1,0,0,1,1,4'hF,10'h000,0,  1,D2),  // read 013
    v("R9 ", 1,1,0,1,0,0,1,1,4'hF,10'h000,0,  1,D3),  // read 010
    v("R8 ", 1,1,0,1,0,1,1,1,4'hF,10'h000,0,  1,D4),  // hold
    v("R8 ", 1,1,0,1,0,1,1,1,4'hF,10'h000,0,  1,D4),
    v("R8 ", 1,0,0,1,0,1,1,0,4'hA,10'h011,W,  1,D4),  // R7 lanes 0,2
    v("R11", 1,0,0,1,0,1,1,1,4'hF,10'h011,0,  0,0),   // R3 controller read
    v("R7 ", 1,1,0,1,0,1,1,1,4'hF,10'h000,0,  1,MRG),
    v("R1 ", 1,0,1,1,0,1,1,1,4'hF,10'h000,0,  1,MRG), // R4 deselect
    v("R4 ", 1,1,0,1,0,1,1,1,4'hF,10'h000,0,  0,0),
    v("R4 ", 0,1,0,1,0,1,1,1,4'hF,10'h013,0,  0,0),
    v("R4 ", 0,1,1,1,0,0,1,1,4'hF,10'h000,0,  1,D3),  // proc ignored: step
    v("R4 ", 1,1,0,1,0,1,1,1,4'hF,10'h000,0,  1,D4),
    v("R5 ", 0,1,0,0,0,1,1,1,4'hF,10'h000,0,  1,D4),  // en2 low
    v("R5 ", 1,1,0,1,0,0,0,1,4'hF,10'h000,JK, 0,0),   // no burst: no write
    v("R5 ", 1,0,0,1,1,1,1,1,4'hF,10'h000,0,  0,0),   // en3_n high
    v("R5 ", 1,0,0,1,0,1,1,1,4'hF,10'h011,0,  0,0),
    v("R5 ", 1,1,0,1,0,1,1,1,4'hF,10'h000,0,  1,MRG),
    v("R4 ", 1,0,1,1,0,1,1,1,4'hF,10'h000,0,  1,MRG),
    v("R4 ", 1,1,0,1,0,1,1,1,4'hF,10'h000,0,  0,0)
  };

  task automatic idle_in();
    ps_n = 1; cs_n = 1; e1n = 0; e2 = 1; e3n = 0; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; addr = '0; din = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic exp_oe,
                     input logic [35:0] exp_q, input logic cmp_q);
    total++;
    if (dout_oe !== exp_oe || (cmp_q && dout !== exp_q)) begin
      bad++;
      $display("FAIL %s: oe=%b q=%h expected oe=%b q=%h",
               tag, dout_oe, dout, exp_oe, exp_q);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_in();
    oe_n = 0; sleep = 0; lin = 1; rst = 1;
    tick(); tick(); tick();
    chk("R12 reset", 1'b0, 36'h0, 1'b1);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      ps_n = TBL[i].ps_n; cs_n = TBL[i].cs_n; e1n = TBL[i].e1n;
      e2 = TBL[i].e2; e3n = TBL[i].e3n; adv_n = TBL[i].adv_n;
      gw_n = TBL[i].gw_n; bwe_n = TBL[i].bwe_n; bw_n = TBL[i].bw_n;
      addr = TBL[i].a; din = TBL[i].d;
      tick();
      if (TBL[i].chk) chk($sformatf("%s table[%0d]", TBL[i].tag, i),
                          TBL[i].oe, TBL[i].q, TBL[i].oe);
    end
    idle_in();

    // R6: write data of a processor burst taken on the next cycle, held address
    ps_n = 0; addr = 10'h020; gw_n = 0; din = JK; tick();
    idle_in(); gw_n = 0; din = D5; tick();
    idle_in(); cs_n = 0; addr = 10'h020; tick();
    idle_in(); tick();
    chk("R6 write after proc open", 1'b1, D5, 1'b1);

    // R7: qualifier low with every select high is a read
    cs_n = 0; bwe_n = 0; addr = 10'h012; din = JK; tick();
    idle_in(); tick();
    chk("R7 all selects high reads", 1'b1, D2, 1'b1);

    // R9: interleaved order from base 1: 1,0,3,2 then wrap to 1
    cs_n = 0; e1n = 1; tick();              // close the burst first
    idle_in(); lin = 0;
    ps_n = 0; addr = 10'h011; tick();
    idle_in(); adv_n = 0; tick();
    chk("R9 interleaved beat0", 1'b1, MRG, 1'b1);
    tick(); chk("R9 interleaved beat1", 1'b1, D4, 1'b1);
    tick(); chk("R9 interleaved beat2", 1'b1, D3, 1'b1);
    tick(); chk("R9 interleaved beat3", 1'b1, D2, 1'b1);
    adv_n = 1; tick();
    chk("R9 interleaved wrap", 1'b1, MRG, 1'b1);
    lin = 1;

    // R11: output enable acts between edges
    oe_n = 1; #1;
    chk("R11 oe_n high", 1'b0, 36'h0, 1'b0);
    oe_n = 0; #1;
    chk("R11 oe_n low again", 1'b1, MRG, 1'b1);

    // R10: sleep in the middle of a held read burst
    sleep = 1; #1;
    chk("R10 sleep immediate", 1'b0, 36'h0, 1'b0);
    tick(); chk("R10 sleep edge", 1'b0, 36'h0, 1'b0);
    adv_n = 0; tick();
    sleep = 0; tick();
    chk("R10 exit stays undriven", 1'b0, 36'h0, 1'b0);
    adv_n = 1; tick();
    chk("R10 burst ended by sleep", 1'b0, 36'h0, 1'b0);
    ps_n = 0; addr = 10'h012; tick();
    idle_in(); tick();
    chk("R10 read after sleep", 1'b1, D2, 1'b1);

    // R12: reset clears the output, memory survives
    rst = 1; tick(); tick();
    chk("R12 reset mid-run", 1'b0, 36'h0, 1'b1);
    rst = 0;
    ps_n = 0; addr = 10'h013; tick();
    idle_in(); tick();
    chk("R12 memory kept", 1'b1, D3, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule